// File: doc/BRIEF.md
# SPI Fan-In Bit-Interleaving Bridge

This block lets one fast SPI master read a group of slow SPI slaves in a single transaction. The block is clocked by the master's SPI clock, and every clock cycle is one fast bit slot. It divides that clock by exactly 32 to make one slave clock, and one slave chip select is shared by every slave. At 60 MHz on the master link, the slaves see a clock of about 1.9 MHz. Each slow period holds 32 fast slots. Once in each slow period, the block samples all slave MISO lines together. In the next slow period it sends the sampled bits back to the master, one per fast slot, on the master's MISO.

The number of slaves `N_SLV` is set at compile time. It must lie between 1 and 32, so that all of one period's slave bits fit in that period's slots. Slots that carry no slave bit are driven low. The data comes back one slow period late. The master must therefore discard the first `N_SLV` bits of every transaction, and then the padding bits that follow in that first period. Master MOSI is sampled once per slow period and held on the shared slave MOSI line. Deasserting the master chip select puts the whole block back in its idle state, so every transaction starts with the same phase.

Top module: `spi_fanin_bridge`

## Requirements
- R1: While `mst_sel_n` is low, `slv_sclk` is low in fast slots 0..15 and high in slots 16..31 of each 32-slot slow period. Slot 0 is the first cycle after the clock edge that first samples `mst_sel_n` low. `slv_sclk` is low while idle.
- R2: `slv_sel_n` is low from slot 0 for as long as the master chip select stays low. It returns high one cycle after `mst_sel_n` is sampled high.
- R3: In slow period p ≥ 1, fast slot s < N_SLV carries the MISO bit of slave s that was sampled at the rising slave-clock edge of period p-1. Slave 0 comes first, in slot 0.
- R4: Every fast slot s ≥ N_SLV carries 0.
- R5: The first N_SLV slots of a transaction (period 0) carry no slave data. They output the cleared capture value, 0, and the master discards them.
- R6: Master MOSI is sampled at the end of slot 0 of each period. Its value is 0 before the first sample. From slot 1 onward it is held on `slv_mosi` until the next sample, so that at the slave-clock rise in slot 16 `slv_mosi` equals the MOSI bit of slot 0.
- R7: When `mst_sel_n` goes high, even in the middle of a period, the block returns to idle one cycle later: `slv_sel_n`=1, `slv_sclk`=0, `mst_miso`=0, `slv_mosi`=0. The next transaction then starts again from slot 0 with cleared capture data.
- R8: While `rst` is high, the outputs hold the idle values of R7, even if `mst_sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master-side SPI bit clock; one cycle per fast bit slot |
| rst | input | 1 | Synchronous active-high reset |
| mst_sel_n | input | 1 | Master chip select, active low |
| mst_mosi | input | 1 | Master data toward the slaves |
| mst_miso | output | 1 | Interleaved slave data toward the master |
| slv_sclk | output | 1 | Shared slave clock, clk divided by 32 |
| slv_sel_n | output | 1 | Shared slave chip select, active low |
| slv_mosi | output | 1 | Shared slave data input, one bit per slow period |
| slv_miso | input | N_SLV | MISO line of each slave, bit i from slave i |

## Verification
A wrong phase count shows in the first slow period as a misplaced `slv_sclk` edge. It also shows one period later as slave bits arriving in the wrong slots of `mst_miso`. A capture or shift register that is not cleared between transactions leaks the previous transaction's bits into the junk slots or the zero padding of the next one. Aborted transactions followed by a restart expose this within 32 slots. A wrong MOSI sample shows at the slave-clock rise of the same period.

// File: rtl/spi_fanin_pkg.sv
package spi_fanin_pkg;

  // fast slots per slow slave-clock period (power of two)
  localparam int unsigned SLOW_DIV = 32;
  localparam int unsigned PH_W     = $clog2(SLOW_DIV);
  localparam int unsigned HALF_DIV = SLOW_DIV / 2;

  typedef logic [PH_W-1:0] phase_t;

  // slot in which the slave clock has just risen: slave MISO is sampled here
  localparam phase_t CAP_SLOT  = phase_t'(HALF_DIV);
  // slot whose master MOSI bit is forwarded
  localparam phase_t TAKE_SLOT = phase_t'(0);

  typedef struct packed {
    logic act;   // master chip select asserted this cycle
    logic load;  // next slot is slot 0: load the output shifter
    logic cap;   // sample slave MISO lines
    logic take;  // sample master MOSI
  } strobe_t;

endpackage

// File: rtl/spi_fanin_phase.sv
module spi_fanin_phase
  import spi_fanin_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mst_sel_n,
  output strobe_t stb,
  output logic    slv_sclk,
  output logic    slv_sel_n
);

  logic   run;
  phase_t ph;
  phase_t ph_nxt;

  always_comb begin
    ph_nxt   = run ? phase_t'(ph + 1'b1) : '0;
    stb.act  = ~mst_sel_n;
    stb.load = ~mst_sel_n & (ph_nxt == '0);
    stb.cap  = ~mst_sel_n & run & (ph == CAP_SLOT);
    stb.take = ~mst_sel_n & run & (ph == TAKE_SLOT);
  end

  always_ff @(posedge clk) begin
    if (rst || mst_sel_n) begin
      run       <= 1'b0;
      ph        <= '0;
      slv_sclk  <= 1'b0;
      slv_sel_n <= 1'b1;
    end else begin
      run       <= 1'b1;
      ph        <= ph_nxt;
      slv_sclk  <= (ph_nxt >= phase_t'(HALF_DIV));
      slv_sel_n <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_fanin_serial.sv
module spi_fanin_serial
  import spi_fanin_pkg::*;
#(
  parameter int unsigned N_SLV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [N_SLV-1:0] slv_miso,
  output logic             mst_miso
);

  logic [N_SLV-1:0] cap_q;
  logic [N_SLV-1:0] sh_q;

  // one capture flop per slave, all sampled at the same slot
  for (genvar i = 0; i < N_SLV; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst || !stb.act) begin
        cap_q[i] <= 1'b0;
      end else if (stb.cap) begin
        cap_q[i] <= slv_miso[i];
      end
    end
  end

  // zero-filling shifter: slave 0 leaves first, padding follows
  always_ff @(posedge clk) begin
    if (rst || !stb.act) begin
      sh_q     <= '0;
      mst_miso <= 1'b0;
    end else if (stb.load) begin
      mst_miso <= cap_q[0];
      sh_q     <= cap_q >> 1;
    end else begin
      mst_miso <= sh_q[0];
      sh_q     <= sh_q >> 1;
    end
  end

endmodule

// File: rtl/spi_fanin_fwd.sv
module spi_fanin_fwd
  import spi_fanin_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  logic    mst_mosi,
  output logic    slv_mosi
);

  always_ff @(posedge clk) begin
    if (rst || !stb.act) begin
      slv_mosi <= 1'b0;
    end else if (stb.take) begin
      slv_mosi <= mst_mosi;
    end
  end

endmodule

// File: rtl/spi_fanin_bridge.sv
module spi_fanin_bridge
  import spi_fanin_pkg::*;
#(
  parameter int unsigned N_SLV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mst_sel_n,
  input  logic             mst_mosi,
  output logic             mst_miso,
  output logic             slv_sclk,
  output logic             slv_sel_n,
  output logic             slv_mosi,
  input  logic [N_SLV-1:0] slv_miso
);

  strobe_t stb;

  spi_fanin_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .mst_sel_n (mst_sel_n),
    .stb       (stb),
    .slv_sclk  (slv_sclk),
    .slv_sel_n (slv_sel_n)
  );

  spi_fanin_serial #(.N_SLV(N_SLV)) u_serial (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .slv_miso (slv_miso),
    .mst_miso (mst_miso)
  );

  spi_fanin_fwd u_fwd (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .mst_mosi (mst_mosi),
    .slv_mosi (slv_mosi)
  );

endmodule

// File: rtl/spi_fanin_chk.sv
module spi_fanin_chk
  import spi_fanin_pkg::*;
#(
  parameter int unsigned N_SLV = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mst_sel_n,
  input logic             mst_miso,
  input logic             slv_sclk,
  input logic             slv_sel_n,
  input logic             slv_mosi,
  input logic [N_SLV-1:0] slv_miso
);

  // slot index seen from the ports, counted from the fall of slv_sel_n
  phase_t slot_q;
  logic   first_q;

  always_ff @(posedge clk) begin
    if (rst || slv_sel_n) begin
      slot_q  <= '0;
      first_q <= 1'b1;
    end else begin
      slot_q <= phase_t'(slot_q + 1'b1);
      if (slot_q == phase_t'(SLOW_DIV - 1)) first_q <= 1'b0;
    end
  end

  // R1
  sclk_shape_chk: assert property (@(posedge clk) disable iff (rst)
    !slv_sel_n |-> (slv_sclk == (slot_q >= phase_t'(HALF_DIV))));

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mst_sel_n |=> !slv_sclk);

  // R2
  sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !mst_sel_n |=> !slv_sel_n);

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!slv_sel_n && (int'(slot_q) >= int'(N_SLV))) |-> !mst_miso);

  // R5
  junk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!slv_sel_n && first_q) |-> !mst_miso);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!slv_sel_n && (slot_q != phase_t'(1))) |-> $stable(slv_mosi));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slv_sel_n |-> (!mst_miso && !slv_mosi && !slv_sclk));

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (slv_sel_n && !slv_sclk && !mst_miso && !slv_mosi));

  logic unused_ok;
  assign unused_ok = ^slv_miso;

endmodule

bind spi_fanin_bridge spi_fanin_chk #(.N_SLV(N_SLV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mst_sel_n (mst_sel_n),
  .mst_miso  (mst_miso),
  .slv_sclk  (slv_sclk),
  .slv_sel_n (slv_sel_n),
  .slv_mosi  (slv_mosi),
  .slv_miso  (slv_miso)
);

// File: tb/spi_fanin_bridge_bench.sv
module spi_fanin_bridge_bench;

  localparam int NS   = 3;
  localparam int DIV  = 32;
  localparam int BITS = 8;
  localparam int FULL = DIV * (BITS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mst_sel_n = 1'b0;
  logic          mst_mosi = 1'b0;
  logic          mst_miso;
  logic          slv_sclk;
  logic          slv_sel_n;
  logic          slv_mosi;
  logic [NS-1:0] slv_miso;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  logic done = 1'b0;

  logic [7:0] pat [NS];
  int sidx = 0;

  always #10 clk = ~clk;

  spi_fanin_bridge #(.N_SLV(NS)) u_spi_fanin_bridge (
    .clk       (clk),
    .rst       (rst),
    .mst_sel_n (mst_sel_n),
    .mst_mosi  (mst_mosi),
    .mst_miso  (mst_miso),
    .slv_sclk  (slv_sclk),
    .slv_sel_n (slv_sel_n),
    .slv_mosi  (slv_mosi),
    .slv_miso  (slv_miso)
  );

  // slave model: MSB first, next bit after each falling slave-clock edge
  always @(negedge slv_sclk or posedge slv_sel_n) begin
    if (slv_sel_n) sidx <= 0;
    else           sidx <= sidx + 1;
  end

  always_comb begin
    for (int i = 0; i < NS; i++)
      slv_miso[i] = (sidx < BITS) ? pat[i][7 - sidx] : 1'b0;
  end

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0b exp=%0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic logic mbit(input int t, input int k);
    return logic'(((k * 7 + t * 3) >> 2) & 1);
  endfunction

  task automatic check_idle(input string tag);
    check(tag, slv_sel_n, 1'b1);
    check(tag, slv_sclk, 1'b0);
    check(tag, mst_miso, 1'b0);
    check(tag, slv_mosi, 1'b0);
  endtask

  task automatic run_txn(input int t, input int nslots, input string rtag);
    for (int i = 0; i < NS; i++) begin
      if (t == 0)      pat[i] = 8'hFF;
      else if (t == 1) pat[i] = 8'h00;
      else             pat[i] = 8'((t * 37 + i * 91 + 5) & 8'hFF);
    end
    @(negedge clk);
    mst_sel_n = 1'b0;
    for (int k = 0; k < nslots; k++) begin
      int p;
      int s;
      logic exp;
      @(negedge clk);
      p = k / DIV;
      s = k % DIV;
      if (s >= NS) begin
        exp = 1'b0;
        check("R4 pad slot", mst_miso, exp);
      end else if (p == 0) begin
        exp = 1'b0;
        check("R5 junk slot", mst_miso, exp);
      end else begin
        exp = (p - 1 < BITS) ? pat[s][7 - (p - 1)] : 1'b0;
        check({rtag, " slave data"}, mst_miso, exp);
      end
      check({rtag == "R7" ? "R7" : "R1", " sclk"}, slv_sclk, logic'(s >= DIV / 2));
      check("R2 sel", slv_sel_n, 1'b0);
      if (s == DIV / 2) check("R6 mosi", slv_mosi, mbit(t, p * DIV));
      mst_mosi = mbit(t, k);
    end
    mst_sel_n = 1'b1;
    mst_mosi  = 1'b0;
    @(negedge clk);
    check_idle("R7 idle after release");
    check("R2 sel release", slv_sel_n, 1'b1);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) pat[i] = 8'h00;
    // R8: reset dominates an asserted master select
    repeat (3) @(negedge clk);
    check_idle("R8 reset");
    mst_sel_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R8 after reset");

    for (int t = 0; t < 6; t++) run_txn(t, FULL, "R3");
    // abort in the middle of period 1, then restart from scratch
    run_txn(6, 50, "R3");
    run_txn(7, FULL, "R7");
    run_txn(8, 40, "R3");
    run_txn(9, FULL, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule